// File: doc/BRIEF.md
# Inbound Requester-to-Group Classifier

This block sits on the inbound side of a host bridge and sorts each arriving request by the agent that issued it. The 16-bit requester ID (bus, device, function) indexes an on-chip table that returns an isolation group number and a valid flag. Every request, whatever its kind, goes through this one lookup. Error messages stop there. Memory requests are then checked against two interrupt address windows. One window is the top 64 KB of the 32-bit space. The other is a parameter-set 64 KB page high in the 64-bit space.

A memory request outside both windows is treated as DMA. One fixed high address bit chooses which of the group's two DMA windows applies. A memory request inside a window is an interrupt message. Its interrupt number comes from the low message-data bits and from which window was hit. A descriptor table, indexed by that number, holds the group allowed to raise the interrupt. The interrupt is forwarded only when that group equals the requester's group. Otherwise the block drops it and reports a violation carrying the requester ID and the interrupt number.

Both tables are filled through one register-style write port. Each classification result appears one clock after the request is presented.

Top module: `rid_group_classifier`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` and `viol_valid` are low. Reset marks every entry of both tables invalid, so a requester looked up before any write reports `out_mapped`=0.
- R2: Each cycle with `in_valid` high yields exactly one cycle of `out_valid` on the next cycle. A cycle without `in_valid` yields `out_valid` low on the next cycle.
- R3: A requester is mapped only when its ID is below 2**RTT_AW (default 256) and its requester-table entry (index = ID) is valid. A mapped requester reports the stored group. An unmapped one reports `out_mapped`=0 and group 0.
- R4: A memory request (`in_kind`=0) whose address falls in neither interrupt window is classed DMA (`out_cls`=0). `out_dma_win` equals address bit 59.
- R5: The low interrupt window is address[63:16] == 48'h0000_0000_FFFF. The high window is address[63:16] == MSI_HI_PAGE (default 48'h0001_0000_0000). A memory request in either window is classed interrupt (`out_cls`=1). An address one byte below the low window is DMA.
- R6: The interrupt number is message data bits [10:0] in the low window. In the high window it is those bits plus 1024, modulo 2048. Data bits above bit 10 are ignored.
- R7: An interrupt is forwarded (`out_irq_fwd`=1) only when the requester is mapped, the descriptor entry for its interrupt number is valid, and the descriptor group equals the requester's group.
- R8: An interrupt that is not forwarded raises `viol_valid` for one cycle, together with `out_valid`. `viol_rid` and `viol_irq` carry the requester ID and the interrupt number.
- R9: An error message (`in_kind`=1) is classed error (`out_cls`=2) and reports only group and mapped status. `out_dma_win`, `out_irq` and `out_irq_fwd` are 0, and no violation is raised, even when the address lies in an interrupt window.
- R10: A write (`cfg_we`) goes to the requester table when `cfg_tbl`=0 and to the descriptor table when `cfg_tbl`=1. It stores `cfg_group` with valid = `cfg_valid`, so `cfg_valid`=0 unmaps the entry. A write to an index beyond the selected table is ignored. A request presented in the same cycle as a write sees the old entry, and later requests see the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 1 | 0 = memory request, 1 = error message |
| in_rid | input | 16 | Requester ID |
| in_addr | input | 64 | Request address |
| in_data | input | 32 | Message data |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | 0 = requester table, 1 = descriptor table |
| cfg_idx | input | 16 | Entry index |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_group | input | 8 | Group number to store |
| out_valid | output | 1 | Classification result valid |
| out_cls | output | 2 | 0 = DMA, 1 = interrupt, 2 = error |
| out_group | output | 8 | Group looked up for the requester |
| out_mapped | output | 1 | Requester has a valid entry |
| out_dma_win | output | 1 | DMA window select |
| out_irq | output | 11 | Interrupt number |
| out_irq_fwd | output | 1 | Interrupt authorized and forwarded |
| viol_valid | output | 1 | Rejected interrupt |
| viol_rid | output | 16 | Requester ID of rejected interrupt |
| viol_irq | output | 11 | Interrupt number of rejected interrupt |

## Verification
The hardest case to reach from the ports is a requester that is correctly mapped but raises an interrupt owned by another group. Producing it needs both tables populated with deliberately mismatched groups. The bench sets up two groups. It then sends one requester's message through the high window, which shifts the interrupt number by 1024 onto a descriptor owned by the other group. It also sends a message whose data sets bits above bit 10, so that masking lands on a foreign descriptor. A table write issued in the same cycle as a request is covered as well, and it shows the old entry being used.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
    localparam int RID_W  = 16;
    localparam int GRP_W  = 8;
    localparam int IRQ_W  = 11;
    localparam int ADDR_W = 64;
    localparam int DATA_W = 32;
    localparam int PAGE_LSB = 16;
    localparam int PAGE_W = ADDR_W - PAGE_LSB;

    typedef enum logic [1:0] {
        CL_DMA = 2'd0,
        CL_IRQ = 2'd1,
        CL_ERR = 2'd2
    } cls_e;

    typedef enum logic {
        K_MEM = 1'b0,
        K_ERR = 1'b1
    } kind_e;

    typedef struct packed {
        cls_e             cls;
        logic [GRP_W-1:0] group;
        logic             mapped;
        logic             dma_win;
        logic [IRQ_W-1:0] irq;
        logic             fwd;
        logic             viol;
    } result_t;

    // High window adds half the interrupt space, wrapping modulo 2**IRQ_W.
    function automatic logic [IRQ_W-1:0] irq_number(input logic hi,
                                                    input logic [IRQ_W-1:0] d);
        logic [IRQ_W-1:0] ofs;
        ofs = '0;
        ofs[IRQ_W-1] = hi;
        return d + ofs;
    endfunction
endpackage

// File: rtl/grp_table.sv
module grp_table #(
    parameter int AW    = 8,
    parameter int GW    = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic          wvalid,
    input  logic [GW-1:0] wgroup,
    input  logic [AW-1:0] ridx,
    output logic          rd_hit,
    output logic [GW-1:0] rd_group
);
    logic [GW-1:0]    grp_mem [DEPTH];
    logic [DEPTH-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (we) begin
            vld[widx] <= wvalid;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            grp_mem[widx] <= wgroup;
        end
    end

    assign rd_hit   = vld[ridx];
    assign rd_group = grp_mem[ridx];
endmodule

// File: rtl/irq_win_decode.sv
module irq_win_decode
    import rgc_pkg::*;
#(
    parameter logic [PAGE_W-1:0] LO_PAGE = 48'h0000_0000_FFFF,
    parameter logic [PAGE_W-1:0] HI_PAGE = 48'h0001_0000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_lo,
    output logic              in_hi
);
    logic [PAGE_W-1:0] page;

    assign page  = addr[ADDR_W-1:PAGE_LSB];
    assign in_lo = (page == LO_PAGE);
    assign in_hi = (page == HI_PAGE) && !in_lo;
endmodule

// File: rtl/rid_group_classifier.sv
module rid_group_classifier
    import rgc_pkg::*;
#(
    parameter int                RTT_AW      = 8,
    parameter int                DMA_SEL_BIT = 59,
    parameter logic [PAGE_W-1:0] MSI_LO_PAGE = 48'h0000_0000_FFFF,
    parameter logic [PAGE_W-1:0] MSI_HI_PAGE = 48'h0001_0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_kind,
    input  logic [15:0]       in_rid,
    input  logic [63:0]       in_addr,
    input  logic [31:0]       in_data,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [15:0]       cfg_idx,
    input  logic              cfg_valid,
    input  logic [7:0]        cfg_group,
    output logic              out_valid,
    output logic [1:0]        out_cls,
    output logic [7:0]        out_group,
    output logic              out_mapped,
    output logic              out_dma_win,
    output logic [10:0]       out_irq,
    output logic              out_irq_fwd,
    output logic              viol_valid,
    output logic [15:0]       viol_rid,
    output logic [10:0]       viol_irq
);
    localparam int RID_HI_W = RID_W - RTT_AW;

    // ---------------- index range checks ----------------
    logic rid_in_range, cfg_rid_ok, cfg_irq_ok;

    generate
        if (RTT_AW < RID_W) begin : g_rid_partial
            assign rid_in_range = (in_rid[RID_W-1:RTT_AW] == '0);
            assign cfg_rid_ok   = (cfg_idx[RID_W-1:RTT_AW] == '0);
        end else begin : g_rid_full
            assign rid_in_range = 1'b1;
            assign cfg_rid_ok   = 1'b1;
        end
    endgenerate

    assign cfg_irq_ok = (cfg_idx[RID_W-1:IRQ_W] == '0);

    // ---------------- requester table ----------------
    logic             rtt_we, rtt_hit;
    logic [GRP_W-1:0] rtt_grp;

    assign rtt_we = cfg_we && !cfg_tbl && cfg_rid_ok;

    grp_table #(.AW(RTT_AW), .GW(GRP_W)) u_rid_tbl (
        .clk     (clk),
        .rst     (rst),
        .we      (rtt_we),
        .widx    (cfg_idx[RTT_AW-1:0]),
        .wvalid  (cfg_valid),
        .wgroup  (cfg_group),
        .ridx    (in_rid[RTT_AW-1:0]),
        .rd_hit  (rtt_hit),
        .rd_group(rtt_grp)
    );

    // ---------------- interrupt window decode ----------------
    logic win_lo, win_hi;

    irq_win_decode #(.LO_PAGE(MSI_LO_PAGE), .HI_PAGE(MSI_HI_PAGE)) u_win (
        .addr (in_addr),
        .in_lo(win_lo),
        .in_hi(win_hi)
    );

    logic [IRQ_W-1:0] irq_n;
    assign irq_n = irq_number(win_hi, in_data[IRQ_W-1:0]);

    // ---------------- descriptor table ----------------
    logic             desc_we, desc_hit;
    logic [GRP_W-1:0] desc_grp;

    assign desc_we = cfg_we && cfg_tbl && cfg_irq_ok;

    grp_table #(.AW(IRQ_W), .GW(GRP_W)) u_desc_tbl (
        .clk     (clk),
        .rst     (rst),
        .we      (desc_we),
        .widx    (cfg_idx[IRQ_W-1:0]),
        .wvalid  (cfg_valid),
        .wgroup  (cfg_group),
        .ridx    (irq_n),
        .rd_hit  (desc_hit),
        .rd_group(desc_grp)
    );

    // ---------------- classification ----------------
    result_t nxt;
    logic    mapped;

    assign mapped = rid_in_range && rtt_hit;

    always_comb begin
        nxt        = '0;
        nxt.cls    = CL_DMA;
        nxt.mapped = mapped;
        nxt.group  = mapped ? rtt_grp : '0;
        if (kind_e'(in_kind) == K_ERR) begin
            nxt.cls = CL_ERR;
        end else if (win_lo || win_hi) begin
            nxt.cls  = CL_IRQ;
            nxt.irq  = irq_n;
            nxt.fwd  = mapped && desc_hit && (desc_grp == rtt_grp);
            nxt.viol = !nxt.fwd;
        end else begin
            nxt.dma_win = in_addr[DMA_SEL_BIT];
        end
    end

    // ---------------- output register ----------------
    result_t         res_q;
    logic            vld_q;
    logic [RID_W-1:0] rid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
            rid_q <= '0;
        end else begin
            vld_q <= in_valid;
            res_q <= in_valid ? nxt : '0;
            rid_q <= in_valid ? in_rid : '0;
        end
    end

    assign out_valid   = vld_q;
    assign out_cls     = res_q.cls;
    assign out_group   = res_q.group;
    assign out_mapped  = res_q.mapped;
    assign out_dma_win = res_q.dma_win;
    assign out_irq     = res_q.irq;
    assign out_irq_fwd = res_q.fwd;
    assign viol_valid  = vld_q && res_q.viol;
    assign viol_rid    = res_q.viol ? rid_q : '0;
    assign viol_irq    = res_q.viol ? res_q.irq : '0;

    logic unused_hi;
    assign unused_hi = ^{in_data[DATA_W-1:IRQ_W], RID_HI_W[0]};
endmodule

// File: rtl/rgc_checker.sv
module rgc_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_kind,
    input logic [15:0] in_rid,
    input logic [63:0] in_addr,
    input logic        out_valid,
    input logic [1:0]  out_cls,
    input logic [7:0]  out_group,
    input logic        out_mapped,
    input logic        out_dma_win,
    input logic        out_irq_fwd,
    input logic        viol_valid,
    input logic [15:0] viol_rid
);
    p_req_gives_out_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_gives_none_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_unmapped_group_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_mapped) |-> (out_group == 8'd0));

    p_dma_window_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_kind) |=> ((out_cls != 2'd0) || (out_dma_win == $past(in_addr[59]))));

    p_fwd_only_irq_r7: assert property (@(posedge clk) disable iff (rst)
        out_irq_fwd |-> (out_valid && out_cls == 2'd1 && out_mapped));

    p_viol_rejected_r8: assert property (@(posedge clk) disable iff (rst)
        viol_valid |-> (out_valid && out_cls == 2'd1 && !out_irq_fwd));

    p_viol_rid_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_kind) |=> (!viol_valid || viol_rid == $past(in_rid)));

    p_err_no_viol_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind) |=> (out_cls == 2'd2 && !viol_valid && !out_irq_fwd));
endmodule

bind rid_group_classifier rgc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_kind    (in_kind),
    .in_rid     (in_rid),
    .in_addr    (in_addr),
    .out_valid  (out_valid),
    .out_cls    (out_cls),
    .out_group  (out_group),
    .out_mapped (out_mapped),
    .out_dma_win(out_dma_win),
    .out_irq_fwd(out_irq_fwd),
    .viol_valid (viol_valid),
    .viol_rid   (viol_rid)
);

// File: tb/rid_group_classifier_test.sv
module rid_group_classifier_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_kind;
    logic [15:0] in_rid;
    logic [63:0] in_addr;
    logic [31:0] in_data;
    logic        cfg_we, cfg_tbl, cfg_valid;
    logic [15:0] cfg_idx;
    logic [7:0]  cfg_group;
    logic        out_valid, out_mapped, out_dma_win, out_irq_fwd, viol_valid;
    logic [1:0]  out_cls;
    logic [7:0]  out_group;
    logic [10:0] out_irq, viol_irq;
    logic [15:0] viol_rid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rid_group_classifier uut (.*);

    typedef struct packed {
        logic        kind;
        logic [15:0] rid;
        logic [63:0] addr;
        logic [31:0] data;
        logic [1:0]  cls;
        logic [7:0]  grp;
        logic        mapped;
        logic        win;
        logic [10:0] irq;
        logic        fwd;
        logic        viol;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        // R4: plain DMA, window 0
        '{1'b0, 16'h0012, 64'h0000_0000_1000_0000, 32'h0, 2'd0, 8'd5, 1'b1, 1'b0, 11'h0,   1'b0, 1'b0},
        // R4: bit 59 set selects window 1
        '{1'b0, 16'h0034, 64'h0800_0000_0000_0000, 32'h0, 2'd0, 8'd9, 1'b1, 1'b1, 11'h0,   1'b0, 1'b0},
        // R5 R7: low window, authorized
        '{1'b0, 16'h0012, 64'h0000_0000_FFFF_0000, 32'h7, 2'd1, 8'd5, 1'b1, 1'b0, 11'h007, 1'b1, 1'b0},
        // R5 R6: high window adds 1024, authorized
        '{1'b0, 16'h0034, 64'h0001_0000_0000_0010, 32'h7, 2'd1, 8'd9, 1'b1, 1'b0, 11'h407, 1'b1, 1'b0},
        // R6 R8: high window lands on another group's descriptor
        '{1'b0, 16'h0012, 64'h0001_0000_0000_0000, 32'h7, 2'd1, 8'd5, 1'b1, 1'b0, 11'h407, 1'b0, 1'b1},
        // R7 R8: unmapped requester
        '{1'b0, 16'h0056, 64'h0000_0000_FFFF_0004, 32'h7, 2'd1, 8'd0, 1'b0, 1'b0, 11'h007, 1'b0, 1'b1},
        // R9: error message in interrupt window
        '{1'b1, 16'h0034, 64'h0000_0000_FFFF_0000, 32'h7, 2'd2, 8'd9, 1'b1, 1'b0, 11'h0,   1'b0, 1'b0},
        // R6: data bits above 10 dropped -> 0x020 owned by group 9
        '{1'b0, 16'h0012, 64'h0000_0000_FFFF_0000, 32'hF820, 2'd1, 8'd5, 1'b1, 1'b0, 11'h020, 1'b0, 1'b1},
        // R7: descriptor never written
        '{1'b0, 16'h0012, 64'h0000_0000_FFFF_0000, 32'h15, 2'd1, 8'd5, 1'b1, 1'b0, 11'h015, 1'b0, 1'b1},
        // R3: requester ID beyond table
        '{1'b0, 16'h1234, 64'h0000_0000_2000_0000, 32'h0, 2'd0, 8'd0, 1'b0, 1'b0, 11'h0,   1'b0, 1'b0},
        // R5: just below low window is DMA
        '{1'b0, 16'h0012, 64'h0000_0000_FFFE_FFFF, 32'h7, 2'd0, 8'd5, 1'b1, 1'b0, 11'h0,   1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic tbl, input logic [15:0] idx,
                             input logic v, input logic [7:0] g);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tbl = tbl; cfg_idx = idx; cfg_valid = v; cfg_group = g;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Presents one request; returns sampled at the negedge after the capturing edge.
    task automatic send(input logic k, input logic [15:0] r,
                        input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_rid = r; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [63:0] pack_out();
        return {29'b0, out_valid, out_cls, out_group, out_mapped, out_dma_win,
                out_irq, out_irq_fwd, viol_valid};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 0; in_kind = 0; in_rid = 0; in_addr = 0; in_data = 0;
        cfg_we = 0; cfg_tbl = 0; cfg_idx = 0; cfg_valid = 0; cfg_group = 0;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {63'b0, out_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", {62'b0, out_valid, viol_valid}, 64'd0);

        // R1: tables empty after reset
        send(1'b0, 16'h0012, 64'h0000_0000_1000_0000, 32'h0);
        check("R1 empty table unmapped", {55'b0, out_valid, out_mapped, out_group}, {55'b0, 1'b1, 1'b0, 8'd0});
        @(negedge clk);
        check("R2 idle cycle no output", {63'b0, out_valid}, 64'd0);

        // R10: populate tables
        cfg_write(1'b0, 16'h0012, 1'b1, 8'd5);
        cfg_write(1'b0, 16'h0034, 1'b1, 8'd9);
        cfg_write(1'b1, 16'h0007, 1'b1, 8'd5);
        cfg_write(1'b1, 16'h0407, 1'b1, 8'd9);
        cfg_write(1'b1, 16'h0020, 1'b1, 8'd9);
        // R10: out-of-range index ignored (would alias 0x12 if truncated)
        cfg_write(1'b0, 16'h0112, 1'b1, 8'd7);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i].kind, VEC[i].rid, VEC[i].addr, VEC[i].data);
            check($sformatf("vector %0d (R2..R9)", i), pack_out(),
                  {29'b0, 1'b1, VEC[i].cls, VEC[i].grp, VEC[i].mapped, VEC[i].win,
                   VEC[i].irq, VEC[i].fwd, VEC[i].viol});
            if (VEC[i].viol)
                check($sformatf("R8 violation info vector %0d", i), {37'b0, viol_rid, viol_irq},
                      {37'b0, VEC[i].rid, VEC[i].irq});
        end

        // R10: same-cycle write sees old entry
        @(negedge clk);
        cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_idx = 16'h0012; cfg_valid = 1'b1; cfg_group = 8'd3;
        in_valid = 1'b1; in_kind = 1'b0; in_rid = 16'h0012; in_addr = 64'h100; in_data = 0;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        check("R10 same-cycle old group", {56'b0, out_group}, 64'd5);
        send(1'b0, 16'h0012, 64'h100, 32'h0);
        check("R10 new group visible", {56'b0, out_group}, 64'd3);

        // R10: unmap with valid=0
        cfg_write(1'b0, 16'h0012, 1'b0, 8'd3);
        send(1'b1, 16'h0012, 64'h100, 32'h0);
        check("R10 unmapped after clear", {55'b0, out_mapped, out_group}, 64'd0);

        // R2: back-to-back requests give consecutive outputs
        @(negedge clk);
        in_valid = 1'b1; in_kind = 1'b1; in_rid = 16'h0034; in_addr = 0;
        @(negedge clk);
        check("R2 back-to-back first", {55'b0, out_valid, out_group}, {55'b0, 1'b1, 8'd9});
        in_rid = 16'h0056;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 back-to-back second", {54'b0, out_valid, out_mapped, out_group}, {54'b0, 1'b1, 1'b0, 8'd0});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule